// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave port on a four-wire serial link (select, serial clock, data in, data out) that gives a host read and write access to a small bank of 8-bit control registers. It runs from the chip's system clock. It brings the slower serial lines into that domain through synchronizer chains and acts on the serial clock edges that it detects there. While select is low, the first byte the host sends is a command. The command carries a direction flag and a 5-bit starting address. Each byte after it is either written into the register at the current address or read back from it, and the address steps by one after every byte.

The register file holds twelve read/write bytes and their reset defaults. It shows all twelve to the rest of the chip as one flat bus. Two further addresses return fixed identification bytes. Everything above them reads as zero and cannot be written.

The control state machine has four states. `ST_IDLE` means no transfer is in progress. `ST_CMD` shifts in the command byte. `ST_WR` writes data bytes. `ST_RD` returns data bytes. Its transitions are as follows:
- IDLE→CMD when select is seen low.
- CMD→WR when the eighth command bit arrives with bit 7 = 1.
- CMD→RD when the eighth command bit arrives with bit 7 = 0.
- CMD, WR or RD→IDLE whenever select is seen high.

Top module: `ser_cfg_port`

## Requirements
- R1: A transfer exists only while ser_sel_n is low. The first byte after ser_sel_n falls is always a command. Raising ser_sel_n returns the port to idle and discards any partial byte, so the next selection starts again with a command byte.
- R2: Command bit 7 = 1 selects write mode and 0 selects read mode. Command bits 4..0 give the starting address. Command bits 6..5 are ignored.
- R3: Every byte travels least significant bit first. ser_din is sampled on the rising edge of ser_clk.
- R4: In read mode, each bit of the addressed register is driven on ser_dout after the falling edge of ser_clk that comes before the rising edge at which the host samples it, starting with bit 0. ser_din is ignored and no register changes.
- R5: After each complete data byte, the address advances by one. The address is 5 bits wide and wraps from 1FH to 00H.
- R6: Addresses 00H..0BH are read/write registers. Register i appears on cfg_q[8*i+7:8*i], and it changes only through a completed write byte.
- R7: After reset the register values are 00H = EDH, 01H = 62H and 03H = 01H, and every other register is 00H. Register 00H holds: bit 7 field polarity, bit 6 blanking mask, bit 5 pixel enable, bit 3 burst, bit 2 setup, bit 0 NTSC. Register 01H holds: bits 7..5 DAC mode = 011, bit 4 input format = 0, bits 3..2 phase = 00, bit 1 interlace = 1.
- R8: Address 0CH reads 14H and 0DH reads 19H. Writes to 0CH and to any higher address are ignored. Reads of addresses 0EH..1FH return 00H.
- R9: ser_dout_en is low while the port is deselected and high while a transfer is selected. ser_dout is 0 outside read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than ser_clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, idles high |
| ser_sel_n | input | 1 | Active-low select |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| ser_dout_en | output | 1 | Output driver enable; low means the line is released (high impedance) |
| cfg_q | output | 96 | The twelve read/write registers, register i at bits 8i+7..8i |

## Verification
The assertions assume that the host keeps ser_clk high whenever ser_sel_n changes. They also assume that every level of ser_clk, ser_sel_n and ser_din is held for many system clocks, so that the synchronized copies change in the same order as the pins. The bench drives every serial edge from tasks that hold each level for ten system clocks. It changes ser_din only while ser_clk is low and moves select only with ser_clk high, so both random and directed traffic stay inside these assumptions.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } ser_state_e;

    // Reset values of the read/write bank (R7)
    function automatic logic [7:0] cfg_default(input int idx);
        case (idx)
            0:       return 8'hED;
            1:       return 8'h62;
            3:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/ser_cfg_fsm.sv
module ser_cfg_fsm
    import ser_cfg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int NUM_RW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] rd_data,
    output ser_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              byte_done,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_en
);

    localparam int              CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] RW_TOP  = ADDR_W'(NUM_RW);

    ser_state_e        state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] shreg;
    logic [ADDR_W-1:0] addr;
    logic              sclk_d;
    logic              dout_q;
    logic              rise, fall;
    logic [DATA_W-1:0] byte_full;

    assign rise      = sclk & ~sclk_d;
    assign fall      = ~sclk & sclk_d;
    assign byte_full = {din, shreg};
    assign byte_done = rise && (bit_cnt == CNT_LAST) && !sel_n;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (!sel_n) state_n = ST_CMD;
            ST_CMD: begin
                if (sel_n)          state_n = ST_IDLE;
                else if (byte_done) state_n = byte_full[DATA_W-1] ? ST_WR : ST_RD;
            end
            ST_WR:   if (sel_n) state_n = ST_IDLE;
            ST_RD:   if (sel_n) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // shift path, bit counter, address pointer and output bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b1;
            bit_cnt <= '0;
            shreg   <= '0;
            addr    <= '0;
            dout_q  <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (state == ST_IDLE || sel_n) begin
                bit_cnt <= '0;
                shreg   <= '0;
                dout_q  <= 1'b0;
            end else begin
                if (rise) begin
                    shreg   <= {din, shreg[DATA_W-2:1]};
                    bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
                end
                if (byte_done) begin
                    if (state == ST_CMD) addr <= byte_full[ADDR_W-1:0];
                    else                 addr <= addr + 1'b1;
                end
                if (fall && state == ST_RD) dout_q <= rd_data[bit_cnt];
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == ST_WR) && byte_done && (addr < RW_TOP);
        wr_data = byte_full;
        dout_en = (state != ST_IDLE);
        dout    = (state == ST_RD) ? dout_q : 1'b0;
        state_o = state;
        addr_o  = addr;
    end

endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
    import ser_cfg_pkg::*;
#(
    parameter int          ADDR_W = 5,
    parameter int          DATA_W = 8,
    parameter int          NUM_RW = 12,
    parameter logic [7:0]  ID_LO  = 8'h14,
    parameter logic [7:0]  ID_HI  = 8'h19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_RW*DATA_W-1:0] cfg_q
);

    localparam logic [ADDR_W-1:0] ID_LO_ADDR = ADDR_W'(NUM_RW);
    localparam logic [ADDR_W-1:0] ID_HI_ADDR = ADDR_W'(NUM_RW + 1);

    logic [DATA_W-1:0] bank [NUM_RW];

    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[i] <= DATA_W'(cfg_default(i));
            else if (wr_en && addr == ADDR_W'(i))
                bank[i] <= wr_data;
        end
        assign cfg_q[i*DATA_W +: DATA_W] = bank[i];
    end

    always_comb begin
        rd_data = '0;
        if (addr == ID_LO_ADDR) rd_data = DATA_W'(ID_LO);
        if (addr == ID_HI_ADDR) rd_data = DATA_W'(ID_HI);
        for (int i = 0; i < NUM_RW; i++)
            if (addr == ADDR_W'(i)) rd_data = bank[i];
    end

endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
    import ser_cfg_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int NUM_RW      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_sel_n,
    input  logic                     ser_din,
    output logic                     ser_dout,
    output logic                     ser_dout_en,
    output logic [NUM_RW*DATA_W-1:0] cfg_q
);

    logic              sclk_s, sel_s, din_s;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic [ADDR_W-1:0] addr;
    logic              wr_en, byte_done;
    ser_state_e        state;

    ser_cfg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_clk, ser_sel_n, ser_din}),
        .d_out ({sclk_s, sel_s, din_s})
    );

    ser_cfg_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_RW (NUM_RW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_s),
        .sclk      (sclk_s),
        .din       (din_s),
        .rd_data   (rd_data),
        .state_o   (state),
        .addr_o    (addr),
        .byte_done (byte_done),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .dout      (ser_dout),
        .dout_en   (ser_dout_en)
    );

    ser_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_RW (NUM_RW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

endmodule

// File: rtl/ser_cfg_chk.sv
module ser_cfg_chk
    import ser_cfg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int NUM_RW = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_s,
    input ser_state_e               state,
    input logic [ADDR_W-1:0]        addr,
    input logic                     byte_done,
    input logic                     wr_en,
    input logic                     ser_dout_en,
    input logic [NUM_RW*DATA_W-1:0] cfg_q
);

    // R1: data phases are entered only through a command byte
    a_r1_cmd_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR || state == ST_RD) |-> $past(state) != ST_IDLE);

    // R5: a finished data byte moves the pointer by one
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WR || state == ST_RD) && byte_done) |=> addr == $past(addr) + 1'b1);

    // R6: the bank holds its value unless a write byte completes
    a_r6_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

    // R8: no write reaches an address at or above the identification bytes
    a_r8_write_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> addr < ADDR_W'(NUM_RW));

    // R9: the driver is released once deselection has settled
    a_r9_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && $past(sel_s)) |-> !ser_dout_en);

endmodule

bind ser_cfg_port ser_cfg_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_RW (NUM_RW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (sel_s),
    .state       (state),
    .addr        (addr),
    .byte_done   (byte_done),
    .wr_en       (wr_en),
    .ser_dout_en (ser_dout_en),
    .cfg_q       (cfg_q)
);

// File: tb/sim_ser_cfg_port.sv
`timescale 1ns/1ps
module sim_ser_cfg_port;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_sel_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_dout, ser_dout_en;
    logic [95:0] cfg_q;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [12];

    always #4 clk = ~clk;

    ser_cfg_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_sel_n   (ser_sel_n),
        .ser_din     (ser_din),
        .ser_dout    (ser_dout),
        .ser_dout_en (ser_dout_en),
        .cfg_q       (cfg_q)
    );

    function automatic logic [7:0] exp_rd(input logic [4:0] a);
        if (a < 5'd12)  return model[a];
        if (a == 5'h0C) return 8'h14;
        if (a == 5'h0D) return 8'h19;
        return 8'h00;
    endfunction

    function automatic logic [95:0] exp_cfg();
        logic [95:0] v;
        for (int i = 0; i < 12; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        ser_sel_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic sel_off();
        ser_sel_n = 1'b1;
        wait_clk(HALF);
    endtask

    // send n bits LSB first, capture what is returned before each rising edge
    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0;
            ser_din = tx[i];
            wait_clk(HALF);
            rx[i]   = ser_dout;
            ser_clk = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic [4:0] a;
        void'($urandom(32'd4711));
        for (int i = 0; i < 12; i++) model[i] = 8'h00;
        model[0] = 8'hED; model[1] = 8'h62; model[3] = 8'h01;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R7 reset defaults, R9 released while idle
        chk("R7 reset bank", cfg_q, exp_cfg());
        chk("R9 enable low when deselected", 96'(ser_dout_en), 96'(0));

        // R8 R4 R5: read burst over the whole address space
        sel_on();
        chk("R9 enable high when selected", 96'(ser_dout_en), 96'(1));
        xfer(8'h00, rx);
        for (int k = 0; k < 32; k++) begin
            xfer(8'($urandom), rx);
            chk($sformatf("R8 R4 read addr %0h", k), 96'(rx), 96'(exp_rd(5'(k))));
        end
        sel_off();
        chk("R4 read leaves bank untouched", cfg_q, exp_cfg());

        // R3 R6 R5: directed write stream
        sel_on();
        xfer(8'h80, rx);
        xfer(8'hFF, rx); model[0] = 8'hFF;
        xfer(8'h11, rx); model[1] = 8'h11;
        xfer(8'hCE, rx); model[2] = 8'hCE;
        chk("R9 dout zero in write mode", 96'(ser_dout), 96'(0));
        sel_off();
        chk("R3 R6 write stream", cfg_q, exp_cfg());

        // R2 ignored command bits 6..5 plus R8 writes above the bank
        sel_on();
        xfer(8'hEB, rx);               // write, start 0BH, bits 6..5 set
        xfer(8'h5A, rx); model[11] = 8'h5A;
        xfer(8'hAA, rx);               // 0CH
        xfer(8'hBB, rx);               // 0DH
        xfer(8'hCC, rx);               // 0EH
        sel_off();
        chk("R2 R8 writes to read-only ignored", cfg_q, exp_cfg());
        sel_on();
        xfer(8'h6C, rx);               // read, start 0CH, bits 6..5 set
        xfer(8'h00, rx); chk("R8 ID low", 96'(rx), 96'(8'h14));
        xfer(8'h00, rx); chk("R8 ID high", 96'(rx), 96'(8'h19));
        xfer(8'h00, rx); chk("R8 above IDs reads zero", 96'(rx), 96'(0));
        sel_off();

        // R5 wrap from 1FH to 00H in read mode
        sel_on();
        xfer(8'h1F, rx);
        xfer(8'h00, rx); chk("R5 read 1FH", 96'(rx), 96'(0));
        xfer(8'h00, rx); chk("R5 wrap to 00H", 96'(rx), 96'(model[0]));
        sel_off();

        // R1 abort inside the command byte
        sel_on();
        xfer_bits(8'h84, 4, rx);
        sel_off();
        chk("R1 partial command discarded", cfg_q, exp_cfg());
        sel_on();
        xfer(8'h04, rx);
        xfer(8'h00, rx); chk("R1 fresh command after abort", 96'(rx), 96'(model[4]));
        sel_off();

        // R1 abort inside a data byte
        sel_on();
        xfer(8'h85, rx);
        xfer(8'hA5, rx); model[5] = 8'hA5;
        xfer_bits(8'hFF, 3, rx);
        sel_off();
        chk("R1 partial data byte discarded", cfg_q, exp_cfg());

        // random traffic against the bench model
        for (int t = 0; t < 40; t++) begin
            logic       wr;
            int         n;
            wr = 1'($urandom);
            a  = 5'($urandom);
            n  = 1 + int'($urandom % 5);
            sel_on();
            xfer({wr, 2'($urandom), a}, rx);
            for (int k = 0; k < n; k++) begin
                if (wr) begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    xfer(d, rx);
                    if (a < 5'd12) model[a] = d;
                end else begin
                    xfer(8'($urandom), rx);
                    chk($sformatf("R4 R5 random read addr %0h", a), 96'(rx), 96'(exp_rd(a)));
                end
                a = a + 5'd1;
            end
            sel_off();
            chk("R6 R2 random bank compare", cfg_q, exp_cfg());
            chk("R9 released after transfer", 96'(ser_dout_en), 96'(0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule